// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is the target side of an SMBus/I2C-style two-wire link that lets a host reach a small bank of byte-wide control registers. Both bus lines are brought into the system clock domain and edge-detected. From these edges the block recognises START, repeated START and STOP, matches a 7-bit device address and runs an indexed block protocol. SDA is driven low only through an output-enable, so the pad stays open-drain.

A block write carries a device address with the write bit, a starting index, a byte count and then the data bytes. A block read sends the device address with the write bit and the starting index. The host then issues a repeated START and the address with the read bit. The target answers with the contents of a dedicated count register, followed by register data from the latched index for as long as the host acknowledges. A parallel local port lets the surrounding logic read and write the same registers.

Top module: `smb_regfile_target`

## Requirements
- R1: SDA is pulled low only while the synchronised SCL is low. SDA bits from the host are taken on rising SCL edges. An SDA fall while SCL is high is a START, and an SDA rise while SCL is high is a STOP.
- R2: The first byte after a START is {7-bit address, R/W}, with R/W = 0 for write and 1 for read. A byte whose address differs from the device address gets no ACK, and all further traffic is ignored until the next START or STOP.
- R3: The device address is {BASE_ADDR[6:1], strap}, with BASE_ADDR = 68h by default. The `addr_strap` input is captured only while reset is asserted. With the strap captured low, the write byte is D0h and the read byte is D1h. A strap change after reset has no effect.
- R4: In a block write, the target ACKs the address, the index N and the count X. Data bytes are stored in register N, then in the following indices. Each stored byte is ACKed.
- R5: A block write stores at most X data bytes. Any data byte beyond the count gets no ACK and is discarded, and the rest of the transfer is ignored.
- R6: A block read is write address, index N, repeated START, then read address. The target returns first the value of the count register at index 8, then the registers starting at N.
- R7: While the host ACKs, the target keeps sending bytes. After a host NACK, SDA stays released until the next START, and a STOP always releases SDA.
- R8: After each byte stored or sent, the index increments. Past index NUM_REGS-1 (11 by default) it wraps to 0.
- R9: Indices at or above NUM_REGS are unimplemented. Writes to them are ACKed and dropped, and reads from them return 00h.
- R10: A START or STOP before the 8th bit of a byte ends the transfer, and the partial byte is never stored.
- R11: `loc_rdata` shows the register at `loc_addr` combinationally, with 00h for unimplemented indices. `loc_we` writes `loc_wdata` there on the clock edge. On a same-cycle clash, a serial write has priority.
- R12: After reset, SDA is released, the count register holds CNT_INIT (8), and every other register holds 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strap | input | 1 | Address-select strap, captured during reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| loc_we | input | 1 | Local register write strobe |
| loc_addr | input | 8 | Local register index |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data (combinational) |

## Verification
Directed block writes and reads are mixed with randomly chosen indices, counts and data. The directed cases separate correct indexing from several kinds of fault: a start at the last register shows whether the index wraps, a count one short of the data shows whether the limit is enforced, and a start above the bank shows whether unimplemented reads return zeros. A foreign address and a strap change after reset tell apart a latched address from a live one. A byte cut off by STOP shows whether partial data is committed. After a host NACK, a read byte clocked without a new START must come back as FFh, which shows whether the target really released the line.

// File: rtl/smb_regfile_pkg.sv
package smb_regfile_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_INDEX,
      ST_COUNT,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_HOSTACK,
      ST_IGNORE
   } smb_state_e;

   function automatic logic [7:0] idx_next(input logic [7:0] idx, input logic [7:0] last);
      return (idx == last) ? 8'd0 : idx + 8'd1;
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   localparam int CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_line_sync: STAGES must be at least 2");
   end

   logic [CHAIN-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= '1;
      else        ff_q <= {ff_q[CHAIN-2:0], din};
   end

   assign lvl  = ff_q[STAGES-1];
   assign rise = ff_q[STAGES-1] & ~ff_q[STAGES];
   assign fall = ~ff_q[STAGES-1] & ff_q[STAGES];
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
   parameter int             NUM_REGS = 12,
   parameter int             CNT_IDX  = 8,
   parameter logic [7:0]     CNT_INIT = 8'd8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_we,
   input  logic [7:0] ser_waddr,
   input  logic [7:0] ser_wdata,
   input  logic [7:0] ser_raddr,
   output logic [7:0] ser_rdata,
   output logic [7:0] cnt_val,
   input  logic       loc_we,
   input  logic [7:0] loc_addr,
   input  logic [7:0] loc_wdata,
   output logic [7:0] loc_rdata
);
   localparam int FLAT_W = NUM_REGS * 8;

   if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_num
      $error("smb_regbank: NUM_REGS must lie in 1..256");
   end
   if (CNT_IDX < 0 || CNT_IDX >= NUM_REGS) begin : g_bad_cnt
      $error("smb_regbank: CNT_IDX must name an implemented register");
   end

   logic [FLAT_W-1:0] flat;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST_VAL = (g == CNT_IDX) ? CNT_INIT : 8'd0;
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= RST_VAL;
         else if (ser_we && ser_waddr == 8'(g))   q <= ser_wdata;
         else if (loc_we && loc_addr == 8'(g))    q <= loc_wdata;
      end
      assign flat[g*8 +: 8] = q;
   end

   always_comb begin
      ser_rdata = 8'd0;
      loc_rdata = 8'd0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ser_raddr == 8'(i)) ser_rdata = flat[i*8 +: 8];
         if (loc_addr  == 8'(i)) loc_rdata = flat[i*8 +: 8];
      end
   end

   assign cnt_val = flat[CNT_IDX*8 +: 8];
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
   import smb_regfile_pkg::*;
#(
   parameter int NUM_REGS = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [6:0] dev_addr,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       sda_lvl,
   input  logic       start_evt,
   input  logic       stop_evt,
   input  logic [7:0] rd_data,
   input  logic [7:0] cnt_val,
   output logic       ser_we,
   output logic [7:0] ser_waddr,
   output logic [7:0] ser_wdata,
   output logic [7:0] ser_raddr,
   output logic       sda_oe
);
   localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

   smb_state_e state_q, after_q;
   logic [3:0] bitcnt_q;
   logic [6:0] sh_q;
   logic [7:0] tx_q, idx_q, rem_q, waddr_q, wdata_q;
   logic       we_q, oe_q, ackdrv_q, more_q;
   logic [7:0] byte_in;

   assign byte_in = {sh_q, sda_lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         after_q  <= ST_IDLE;
         bitcnt_q <= '0;
         sh_q     <= '0;
         tx_q     <= '0;
         idx_q    <= '0;
         rem_q    <= '0;
         waddr_q  <= '0;
         wdata_q  <= '0;
         we_q     <= 1'b0;
         oe_q     <= 1'b0;
         ackdrv_q <= 1'b0;
         more_q   <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (start_evt) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
            oe_q     <= 1'b0;
            ackdrv_q <= 1'b0;
            more_q   <= 1'b0;
         end else if (stop_evt) begin
            state_q  <= ST_IDLE;
            oe_q     <= 1'b0;
            ackdrv_q <= 1'b0;
            more_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                  if (scl_rise) begin
                     sh_q     <= byte_in[6:0];
                     bitcnt_q <= bitcnt_q + 4'd1;
                     if (bitcnt_q == 4'd7) begin
                        state_q <= ST_ACK;
                        if (state_q == ST_ADDR) begin
                           if (byte_in[7:1] == dev_addr) begin
                              after_q <= byte_in[0] ? ST_TX : ST_INDEX;
                              tx_q    <= cnt_val;
                           end else begin
                              state_q <= ST_IGNORE;
                           end
                        end else if (state_q == ST_INDEX) begin
                           idx_q   <= byte_in;
                           after_q <= ST_COUNT;
                        end else if (state_q == ST_COUNT) begin
                           rem_q   <= byte_in;
                           after_q <= ST_WDATA;
                        end else if (rem_q != 8'd0) begin
                           we_q    <= 1'b1;
                           waddr_q <= idx_q;
                           wdata_q <= byte_in;
                           idx_q   <= idx_next(idx_q, LAST_IDX);
                           rem_q   <= rem_q - 8'd1;
                           after_q <= ST_WDATA;
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (!ackdrv_q) begin
                        oe_q     <= 1'b1;
                        ackdrv_q <= 1'b1;
                     end else begin
                        ackdrv_q <= 1'b0;
                        bitcnt_q <= '0;
                        state_q  <= after_q;
                        oe_q     <= (after_q == ST_TX) ? ~tx_q[7] : 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) bitcnt_q <= bitcnt_q + 4'd1;
                  if (scl_fall) begin
                     if (bitcnt_q == 4'd8) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_HOSTACK;
                     end else begin
                        oe_q <= ~tx_q[3'd7 - bitcnt_q[2:0]];
                     end
                  end
               end
               ST_HOSTACK: begin
                  if (scl_rise) begin
                     if (!sda_lvl) begin
                        tx_q   <= rd_data;
                        idx_q  <= idx_next(idx_q, LAST_IDX);
                        more_q <= 1'b1;
                     end else begin
                        state_q <= ST_IGNORE;
                     end
                  end
                  if (scl_fall && more_q) begin
                     more_q   <= 1'b0;
                     oe_q     <= ~tx_q[7];
                     bitcnt_q <= '0;
                     state_q  <= ST_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ser_we    = we_q;
   assign ser_waddr = waddr_q;
   assign ser_wdata = wdata_q;
   assign ser_raddr = idx_q;
   assign sda_oe    = oe_q;
endmodule

// File: rtl/smb_regfile_target.sv
module smb_regfile_target #(
   parameter logic [6:0] BASE_ADDR   = 7'h68,
   parameter bit         STRAP_EN    = 1'b1,
   parameter int         NUM_REGS    = 12,
   parameter int         CNT_IDX     = 8,
   parameter logic [7:0] CNT_INIT    = 8'd8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       addr_strap,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       loc_we,
   input  logic [7:0] loc_addr,
   input  logic [7:0] loc_wdata,
   output logic [7:0] loc_rdata
);
   logic       scl_lvl, scl_rise, scl_fall;
   logic       sda_lvl, sda_rise, sda_fall;
   logic       start_evt, stop_evt;
   logic [6:0] dev_addr;
   logic       ser_we;
   logic [7:0] ser_waddr, ser_wdata, ser_raddr, ser_rdata, cnt_val;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
   );

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
   );

   assign start_evt = sda_fall & scl_lvl;
   assign stop_evt  = sda_rise & scl_lvl;

   if (STRAP_EN) begin : g_strap
      logic strap_q;
      always_ff @(posedge clk) begin
         if (!rst_n) strap_q <= addr_strap;
      end
      assign dev_addr = {BASE_ADDR[6:1], strap_q};
   end else begin : g_fixed
      logic strap_unused;
      assign strap_unused = addr_strap;
      assign dev_addr     = BASE_ADDR;
   end

   smb_proto_fsm #(.NUM_REGS(NUM_REGS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .rd_data(ser_rdata), .cnt_val(cnt_val),
      .ser_we(ser_we), .ser_waddr(ser_waddr), .ser_wdata(ser_wdata),
      .ser_raddr(ser_raddr), .sda_oe(sda_oe)
   );

   smb_regbank #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .CNT_INIT(CNT_INIT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ser_we(ser_we), .ser_waddr(ser_waddr), .ser_wdata(ser_wdata),
      .ser_raddr(ser_raddr), .ser_rdata(ser_rdata), .cnt_val(cnt_val),
      .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata)
   );
endmodule

// File: rtl/smb_regfile_target_chk.sv
module smb_regfile_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic scl_rise,
   input logic start_evt,
   input logic stop_evt,
   input logic sda_oe,
   input logic ser_we
);
   AST_DRIVE_WHEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl); // R1

   AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe); // R7

   AST_STORE_AFTER_SCL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ser_we |-> $past(scl_rise)); // R4

   AST_STORE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ser_we |=> !ser_we); // R4

   AST_START_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !ser_we); // R10
endmodule

bind smb_regfile_target smb_regfile_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
   .start_evt(start_evt), .stop_evt(stop_evt), .sda_oe(sda_oe), .ser_we(ser_we)
);

// File: tb/smb_regfile_target_tb.sv
module smb_regfile_target_tb;
   localparam int NREG = 12;
   localparam int Q    = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_strap = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic sda_oe;
   logic sda_line;
   logic loc_we = 1'b0;
   logic [7:0] loc_addr = 8'd0;
   logic [7:0] loc_wdata = 8'd0;
   logic [7:0] loc_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int r1_err = 0;

   logic [7:0] mdl [NREG];
   logic [7:0] wbuf [8];
   logic [7:0] rbuf [16];
   logic       wack [8];
   logic       hdr_ack;
   logic [7:0] rcnt;

   always #5 clk = ~clk;

   assign sda_line = sda_h & ~sda_oe;

   smb_regfile_target u_dut (
      .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
      .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe),
      .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
      .loc_rdata(loc_rdata)
   );

   function automatic logic [7:0] nxt(input logic [7:0] i);
      return (i == 8'(NREG - 1)) ? 8'd0 : i + 8'd1;
   endfunction

   function automatic logic [7:0] mdl_rd(input logic [7:0] i);
      return (i < 8'(NREG)) ? mdl[i] : 8'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; w(Q);
      scl_h = 1'b1; w(Q);
      sda_h = 1'b0; w(Q);
      scl_h = 1'b0; w(Q);
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; w(Q);
      scl_h = 1'b1; w(Q);
      sda_h = 1'b1; w(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 7; i > 7 - nb; i--) begin
         sda_h = b[i]; w(Q);
         scl_h = 1'b1; w(2*Q);
         scl_h = 1'b0; w(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_h = 1'b1; w(Q);
      scl_h = 1'b1; w(Q);
      ack = ~sda_line; w(Q);
      scl_h = 1'b0; w(Q);
   endtask

   task automatic recv_byte(input logic host_ack, output logic [7:0] b);
      logic early;
      for (int i = 7; i >= 0; i--) begin
         sda_h = 1'b1; w(Q);
         scl_h = 1'b1; w(Q);
         early = sda_line; b[i] = early; w(Q - 1);
         if (sda_line !== early) r1_err++;
         w(1);
         scl_h = 1'b0; w(Q);
      end
      sda_h = ~host_ack; w(Q);
      scl_h = 1'b1; w(2*Q);
      scl_h = 1'b0; w(Q);
      sda_h = 1'b1;
   endtask

   task automatic blk_write(input logic [7:0] a8, input logic [7:0] n,
                            input logic [7:0] x, input int nd);
      logic a0, a1, a2;
      bus_start();
      send_byte(a8, a0);
      send_byte(n, a1);
      send_byte(x, a2);
      hdr_ack = a0 & a1 & a2;
      for (int i = 0; i < nd; i++) send_byte(wbuf[i], wack[i]);
      bus_stop();
   endtask

   task automatic write_model(input string tag, input logic [7:0] n,
                              input logic [7:0] x, input int nd);
      logic [7:0] idx;
      blk_write(8'hD0, n, x, nd);
      chk({tag, " header ACK"}, 32'(hdr_ack), 32'd1);
      idx = n;
      for (int i = 0; i < nd; i++) begin
         chk({tag, " data ACK"}, 32'(wack[i]), 32'(i < int'(x)));
         if (i < int'(x)) begin
            if (idx < 8'(NREG)) mdl[idx] = wbuf[i];
            idx = nxt(idx);
         end
      end
   endtask

   task automatic blk_read(input logic [7:0] n, input int nb);
      logic a0, a1, a2;
      bus_start();
      send_byte(8'hD0, a0);
      send_byte(n, a1);
      bus_start();
      send_byte(8'hD1, a2);
      hdr_ack = a0 & a1 & a2;
      recv_byte(nb > 0, rcnt);
      for (int i = 0; i < nb; i++) recv_byte(i < nb - 1, rbuf[i]);
      bus_stop();
   endtask

   task automatic read_check(input string tag, input logic [7:0] n, input int nb);
      logic [7:0] idx;
      blk_read(n, nb);
      chk({tag, " header ACK"}, 32'(hdr_ack), 32'd1);
      chk({tag, " count byte R6"}, 32'(rcnt), 32'(mdl[8]));
      idx = n;
      for (int i = 0; i < nb; i++) begin
         chk({tag, " data"}, 32'(rbuf[i]), 32'(mdl_rd(idx)));
         idx = nxt(idx);
      end
      chk({tag, " SDA released after STOP R7"}, 32'(sda_oe), 32'd0);
   endtask

   task automatic loc_peek(input string tag, input logic [7:0] a);
      loc_addr = a; w(1);
      chk(tag, 32'(loc_rdata), 32'(mdl_rd(a)));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic a;
      logic [7:0] b, v;
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < NREG; i++) mdl[i] = (i == 8) ? 8'd8 : 8'd0;

      w(6);
      rst_n = 1'b1;
      w(2);
      addr_strap = 1'b1;   // late change must not move the address (R3)
      w(4);

      // R12 reset state
      chk("R12 SDA released", 32'(sda_oe), 32'd0);
      loc_peek("R12 count reg reset", 8'd8);
      loc_peek("R12 reg3 reset", 8'd3);

      // R4 / R3: block write at D0h
      wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h7E;
      write_model("R4 R3 write N=2", 8'd2, 8'd3, 3);
      loc_peek("R4 reg2", 8'd2);
      loc_peek("R4 reg4", 8'd4);

      // R2 / R3: foreign address D2h is ignored
      wbuf[0] = 8'hFF;
      blk_write(8'hD2, 8'd2, 8'd1, 1);
      chk("R2 R3 foreign address NACK", 32'(hdr_ack), 32'd0);
      chk("R2 data ignored NACK", 32'(wack[0]), 32'd0);
      loc_peek("R2 reg2 untouched", 8'd2);

      // R6 / R7: read with default count 8
      read_check("R6 read N=2", 8'd2, 8);

      // count register set to 3 through the bus, then wrap on read (R8)
      wbuf[0] = 8'd3;
      write_model("R6 set count", 8'd8, 8'd1, 1);
      read_check("R8 read wrap N=10", 8'd10, 3);

      // R8 write wrap
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      write_model("R8 write wrap N=11", 8'd11, 8'd3, 3);
      loc_peek("R8 reg11", 8'd11);
      loc_peek("R8 reg0", 8'd0);
      loc_peek("R8 reg1", 8'd1);

      // R5 count limit
      wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
      write_model("R5 limit X=2", 8'd4, 8'd2, 3);
      loc_peek("R5 reg6 untouched", 8'd6);

      // R9 unimplemented indices
      wbuf[0] = 8'h99; wbuf[1] = 8'h98;
      write_model("R9 write N=40h", 8'h40, 8'd2, 2);
      read_check("R9 read N=40h", 8'h40, 3);
      loc_peek("R9 local read 40h", 8'h40);

      // R10 STOP mid-byte
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd5, a);
      send_byte(8'd1, a);
      send_bits(8'hC3, 4);
      bus_stop();
      loc_peek("R10 reg5 not committed", 8'd5);

      // R7 after NACK the target stays off the line
      bus_start();
      send_byte(8'hD0, a);
      send_byte(8'd2, a);
      bus_start();
      send_byte(8'hD1, a);
      recv_byte(1'b0, b);
      chk("R7 count then NACK", 32'(b), 32'(mdl[8]));
      recv_byte(1'b0, b);
      chk("R7 no drive after NACK", 32'(b), 32'hFF);
      bus_stop();
      chk("R7 released", 32'(sda_oe), 32'd0);

      // R11 local write seen on the bus
      v = 8'($urandom_range(1, 255));
      loc_addr = 8'd7; loc_wdata = v; loc_we = 1'b1; w(1);
      loc_we = 1'b0;
      mdl[7] = v;
      read_check("R11 local write bus read", 8'd7, 1);
      loc_peek("R11 local read", 8'd7);

      // random block writes and reads
      for (int it = 0; it < 14; it++) begin
         logic [7:0] n, x;
         n = 8'($urandom_range(0, NREG - 1));
         x = 8'($urandom_range(1, 4));
         for (int k = 0; k < int'(x); k++) wbuf[k] = 8'($urandom);
         write_model("R4 R8 random write", n, x, int'(x));
         loc_peek("R11 random local read", n);
         read_check("R6 R8 random read", n, int'(x));
      end

      chk("R1 SDA stable while SCL high", 32'(r1_err), 32'd0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule